// File: doc/BRIEF.md
# Four-Phase Pipelined Instruction Sequencer

This block paces a small processor core. It splits every instruction cycle into four clock phases, Q1 to Q4, and runs a two-stage overlapped pipeline. While one instruction word is being fetched from program memory, the word fetched in the previous cycle sits in the instruction register and is decoded and executed. Because the two stages overlap, a straight-line instruction finishes once every four clocks.

The sequencer owns the fetch address. It moves the address forward by one instruction word (two bytes) at every cycle boundary. It gives the surrounding datapath timing strobes: an operand-read strobe in Q2 and a destination-write strobe in Q4. When the executing instruction reports a taken branch, the sequencer loads the branch target as the next fetch address. The word that was already prefetched behind the branch is dropped, and that slot runs as a forced NOP with its strobes held low.

Opcode decoding, the ALU and the memories lie outside the block.

Top module: `qphase_seq`

## Requirements
- R1: While reset is asserted (asynchronously, active low), the outputs are all at their reset values: phase reads Q1, the instruction register is 0, the valid flag is 0, both strobes are 0, and the fetch address equals the reset vector (0 by default). After reset is released, the first instruction cycle executes a NOP.
- R2: The phase output steps one value per clock in the order Q1=0, Q2=1, Q3=2, Q4=3, and goes from Q4 back to Q1.
- R3: The fetch-advance strobe is 1 during Q1 and 0 during Q2, Q3 and Q4.
- R4: The fetch address changes only at the clock edge that ends Q4. When there is no redirect, it grows by 2 at that edge.
- R5: At the edge that ends Q4, the instruction register loads the word on the fetch-word input, and the valid flag becomes 1 unless the cycle is being flushed.
- R6: The operand-read strobe is 1 only in Q2, and the destination-write strobe is 1 only in Q4. Both require the valid flag to be 1. In a valid cycle each strobe is high for exactly its own phase.
- R7: If the branch-taken input is 1 at the edge that ends Q4 of a valid cycle, the next cycle behaves as follows: the fetch address equals the target, the instruction register reads 0, the valid flag is 0, and neither strobe is asserted.
- R8: In the cycle after a flushed cycle, the word fetched from the target executes with the valid flag at 1, and the fetch address equals the target plus 2.
- R9: The branch-taken input has no effect during a cycle whose valid flag is 0.
- R10: The fetch address loaded from a branch target always has bit 0 cleared.
- R11: The branch-taken input is sampled only at the edge that ends Q4. A pulse that is confined to Q1 through Q3 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase clock; one edge per Q phase |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_word | input | 16 | Instruction word read from program memory at fetch_addr |
| br_taken | input | 1 | The executing instruction changes program flow |
| br_target | input | 21 | Byte address of the branch target |
| phase | output | 2 | Current phase, Q1=0 to Q4=3 |
| fetch_adv | output | 1 | High in Q1, when a new fetch address is presented |
| fetch_addr | output | 21 | Byte address of the word being fetched |
| ir | output | 16 | Instruction register (word in execute) |
| ir_valid | output | 1 | 1 for a real instruction, 0 for a forced NOP |
| rd_stb | output | 1 | Operand-read strobe (Q2 of valid cycles) |
| wr_stb | output | 1 | Destination-write strobe (Q4 of valid cycles) |

## Verification
The first pattern is a straight run of sequential fetches. It shows whether the phase order, the step of 2 in the fetch address and the placement of the strobes are right, and whether the instruction register lags the fetch address by exactly one cycle. A branch raised at the end of a valid cycle separates a correct flush (NOP slot, target fetched) from a design that lets the stale word run. A second branch raised inside that NOP slot shows whether a cancelled instruction can still redirect. An odd target, a branch pulse that ends before Q4, and a reset applied in the middle of a run cover target alignment, the sampling point of the branch input, and the asynchronous return to the reset state.

// File: rtl/qseq_pkg.sv
package qseq_pkg;
  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } qph_e;
endpackage

// File: rtl/qseq_phase_gen.sv
module qseq_phase_gen
  import qseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output qph_e phase,
  output logic cyc_end
);
  qph_e phase_q, phase_d;

  always_comb begin
    unique case (phase_q)
      PH_Q1:   phase_d = PH_Q2;
      PH_Q2:   phase_d = PH_Q3;
      PH_Q3:   phase_d = PH_Q4;
      default: phase_d = PH_Q1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_Q1;
    else        phase_q <= phase_d;
  end

  assign phase   = phase_q;
  assign cyc_end = (phase_q == PH_Q4);

  // R2: the phase moves forward by one value on every clock
  p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_Q4) |=> (phase_q == qph_e'($past(phase_q) + 2'd1)));
  // R2: Q4 is followed by Q1
  p_phase_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_Q4) |=> (phase_q == PH_Q1));
endmodule

// File: rtl/qseq_fetch_ctl.sv
module qseq_fetch_ctl #(
  parameter int unsigned AW         = 21,
  parameter int unsigned ALIGN_BITS = 1,
  parameter logic [AW-1:0] RST_VEC  = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_end,
  input  logic          redirect,
  input  logic [AW-1:0] target,
  output logic [AW-1:0] fetch_addr
);
  localparam logic [AW-1:0] STEP = AW'(1) << ALIGN_BITS;

  logic [AW-1:0] tgt_aligned;
  logic [AW-1:0] pc_q, pc_d;

  generate
    if (ALIGN_BITS == 0) begin : g_no_align
      assign tgt_aligned = target;
    end else begin : g_align
      assign tgt_aligned = {target[AW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    end
  endgenerate

  always_comb begin
    pc_d = pc_q;
    if (cyc_end) begin
      if (redirect) pc_d = tgt_aligned;
      else          pc_d = pc_q + STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RST_VEC;
    else        pc_q <= pc_d;
  end

  assign fetch_addr = pc_q;

  // R4: the fetch address holds for the whole instruction cycle
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_end |=> $stable(pc_q));
  // R4: with no redirect, the address moves by exactly one word
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end && !redirect) |=> (pc_q == $past(pc_q) + STEP));
endmodule

// File: rtl/qseq_exec_stage.sv
module qseq_exec_stage
  import qseq_pkg::*;
#(
  parameter int unsigned IW        = 16,
  parameter logic [IW-1:0] NOP_WORD = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  qph_e          phase,
  input  logic          cyc_end,
  input  logic          flush,
  input  logic [IW-1:0] fetch_word,
  output logic [IW-1:0] ir,
  output logic          ir_valid,
  output logic          rd_stb,
  output logic          wr_stb
);
  logic [IW-1:0] ir_q, ir_d;
  logic          vld_q, vld_d;

  always_comb begin
    ir_d  = ir_q;
    vld_d = vld_q;
    if (cyc_end) begin
      if (flush) begin
        ir_d  = NOP_WORD;
        vld_d = 1'b0;
      end else begin
        ir_d  = fetch_word;
        vld_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q  <= NOP_WORD;
      vld_q <= 1'b0;
    end else begin
      ir_q  <= ir_d;
      vld_q <= vld_d;
    end
  end

  assign ir       = ir_q;
  assign ir_valid = vld_q;
  assign rd_stb   = vld_q && (phase == PH_Q2);
  assign wr_stb   = vld_q && (phase == PH_Q4);

  // R7: a flushed slot becomes a NOP
  p_flush_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end && flush) |=> (!vld_q && ir_q == NOP_WORD));
  // R5: the instruction register changes only at a cycle boundary
  p_ir_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_end |=> ($stable(ir_q) && $stable(vld_q)));
endmodule

// File: rtl/qphase_seq.sv
module qphase_seq
  import qseq_pkg::*;
#(
  parameter int unsigned IW         = 16,
  parameter int unsigned AW         = 21,
  parameter int unsigned ALIGN_BITS = 1,
  parameter logic [AW-1:0] RST_VEC  = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] fetch_word,
  input  logic          br_taken,
  input  logic [AW-1:0] br_target,
  output logic [1:0]    phase,
  output logic          fetch_adv,
  output logic [AW-1:0] fetch_addr,
  output logic [IW-1:0] ir,
  output logic          ir_valid,
  output logic          rd_stb,
  output logic          wr_stb
);
  localparam logic [AW-1:0] STEP = AW'(1) << ALIGN_BITS;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  qph_e       ph;
  logic       cyc_end;
  logic       redirect;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  qseq_phase_gen i_phase (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .phase   (ph),
    .cyc_end (cyc_end)
  );

  // only a real instruction may change program flow
  assign redirect = br_taken && ir_valid;

  qseq_fetch_ctl #(
    .AW         (AW),
    .ALIGN_BITS (ALIGN_BITS),
    .RST_VEC    (RST_VEC)
  ) i_fetch (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cyc_end    (cyc_end),
    .redirect   (redirect),
    .target     (br_target),
    .fetch_addr (fetch_addr)
  );

  qseq_exec_stage #(
    .IW (IW)
  ) i_exec (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .phase      (ph),
    .cyc_end    (cyc_end),
    .flush      (redirect),
    .fetch_word (fetch_word),
    .ir         (ir),
    .ir_valid   (ir_valid),
    .rd_stb     (rd_stb),
    .wr_stb     (wr_stb)
  );

  assign phase     = ph;
  assign fetch_adv = (ph == PH_Q1);

  // R6: strobes sit in their own phase and need a real instruction
  p_rd_place_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_stb |-> (ph == PH_Q2 && ir_valid && !wr_stb));
  p_wr_place_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_stb |-> (ph == PH_Q4 && ir_valid && !rd_stb));
  // R9: a NOP slot never redirects, so the next slot is a sequential one
  p_nop_ignore_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ph == PH_Q4 && !ir_valid) |=> (ir_valid && fetch_addr == $past(fetch_addr) + STEP));
  // R3: the advance strobe marks the first phase of each cycle
  p_adv_q1_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    fetch_adv |=> !fetch_adv);
endmodule

// File: tb/test_qphase_seq.sv
`timescale 1ns/1ps
module test_qphase_seq;
  localparam int IW = 16;
  localparam int AW = 21;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [IW-1:0] fetch_word;
  logic          br_taken;
  logic [AW-1:0] br_target;
  logic [1:0]    phase;
  logic          fetch_adv;
  logic [AW-1:0] fetch_addr;
  logic [IW-1:0] ir;
  logic          ir_valid;
  logic          rd_stb;
  logic          wr_stb;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  qphase_seq i_qphase_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_word (fetch_word),
    .br_taken   (br_taken),
    .br_target  (br_target),
    .phase      (phase),
    .fetch_adv  (fetch_adv),
    .fetch_addr (fetch_addr),
    .ir         (ir),
    .ir_valid   (ir_valid),
    .rd_stb     (rd_stb),
    .wr_stb     (wr_stb)
  );

  function automatic logic [IW-1:0] mem_word(input logic [AW-1:0] a);
    return a[IW-1:0] ^ 16'h5A3C;
  endfunction

  always_comb fetch_word = mem_word(fetch_addr);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic goto_phase(input logic [1:0] p);
    for (int i = 0; i < 8 && phase !== p; i++) step();
  endtask

  // R1: reset values, then the first cycle runs a NOP
  task automatic t_reset();
    rst_n = 1'b0; br_taken = 1'b0; br_target = '0;
    repeat (3) step();
    check("R1 phase", phase, 0);
    check("R1 ir", ir, 0);
    check("R1 valid", ir_valid, 0);
    check("R1 addr", fetch_addr, 0);
    check("R1 strobes", {rd_stb, wr_stb}, 0);
    rst_n = 1'b1;
    goto_phase(2'd1);
    check("R1 first cycle nop rd", rd_stb, 0);
    goto_phase(2'd3);
    check("R1 first cycle nop wr", wr_stb, 0);
    step();
  endtask

  // R2 R3 R4 R5 R6: straight-line fetch and execute
  task automatic t_linear();
    logic [AW-1:0] pc;
    goto_phase(2'd0);
    pc = fetch_addr;
    for (int k = 0; k < 5; k++) begin
      check("R2 q1", phase, 0);
      check("R3 adv q1", fetch_adv, 1);
      check("R5 ir", ir, 32'(mem_word(pc - 21'd2)));
      check("R5 valid", ir_valid, 1);
      step();
      check("R2 q2", phase, 1);
      check("R3 adv q2", fetch_adv, 0);
      check("R6 rd q2", {rd_stb, wr_stb}, 2'b10);
      step();
      check("R2 q3", phase, 2);
      check("R6 q3", {rd_stb, wr_stb}, 2'b00);
      check("R4 hold", fetch_addr, pc);
      step();
      check("R2 q4", phase, 3);
      check("R6 wr q4", {rd_stb, wr_stb}, 2'b01);
      step();
      pc = pc + 21'd2;
      check("R4 step", fetch_addr, pc);
    end
  endtask

  // R7 R8 R9 R10: taken branch, then a branch request inside the NOP slot
  task automatic t_branch(input logic [AW-1:0] tgt);
    logic [AW-1:0] t_even;
    t_even = {tgt[AW-1:1], 1'b0};
    goto_phase(2'd3);
    br_taken = 1'b1; br_target = tgt;
    step();
    br_taken = 1'b0;
    check("R7 addr", fetch_addr, t_even);
    check("R10 even", fetch_addr[0], 0);
    check("R7 ir nop", ir, 0);
    check("R7 valid", ir_valid, 0);
    step();
    check("R7 no rd", rd_stb, 0);
    step(); step();
    check("R7 no wr", wr_stb, 0);
    br_taken = 1'b1; br_target = 21'h00_0400;
    step();
    br_taken = 1'b0;
    check("R9 ignored addr", fetch_addr, t_even + 21'd2);
    check("R8 target ir", ir, 32'(mem_word(t_even)));
    check("R8 target valid", ir_valid, 1);
  endtask

  // R11: a pulse that ends before Q4 is ignored
  task automatic t_early_pulse();
    logic [AW-1:0] pc;
    goto_phase(2'd0);
    pc = fetch_addr;
    br_taken = 1'b1; br_target = 21'h00_0800;
    step(); step(); step();
    br_taken = 1'b0;
    step();
    check("R11 addr", fetch_addr, pc + 21'd2);
    check("R11 valid", ir_valid, 1);
  endtask

  // R1: reset asserted in the middle of a run acts at once
  task automatic t_mid_reset();
    goto_phase(2'd2);
    rst_n = 1'b0;
    #1;
    check("R1 async phase", phase, 0);
    check("R1 async addr", fetch_addr, 0);
    check("R1 async valid", ir_valid, 0);
    step();
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_linear();
    t_branch(21'h00_0124);
    t_linear();
    t_branch(21'h00_0361);
    t_early_pulse();
    t_mid_reset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule